// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block picks the core clock from two free-running sources: the raw clock arriving on the input pin and the output of an on-chip frequency synthesizer. Software asks for the synthesized clock through one select bit. The block honours that request only while the synthesizer reports that it has locked. If lock is lost, or the select bit is cleared, the block falls back to the input-pin clock.

Each source has its own gating leg. A leg's enable request is the arbitrated wish for that source, qualified by the other leg's enable being off. That request passes through a two-flop synchronizer clocked on the falling edge of the leg's own clock. The request therefore reaches each domain at a point where that clock is low. The old source's gate closes before the new one opens. Between the two, the output is held low, so it never carries a phase shorter than those of its sources.

A status bit reports which source drives the core. It is updated only on edges of the gated output clock, so it moves after the new source's gate has opened. While reset is low, the output follows the input-pin clock directly.

Top module: `clk_src_switch`

## Requirements
- R1: While rst_n is low, core_clk_o equals ref_clk_i and, after at least two ref_clk_i cycles, on_pll_o is 0.
- R2: After reset with sel_pll_i = 0, core_clk_o follows ref_clk_i and on_pll_o is 0.
- R3: With sel_pll_i = 1 and lock_i = 1 held, core_clk_o follows pll_clk_i within 12 ref_clk_i cycles and on_pll_o reads 1.
- R4: With sel_pll_i = 1 and lock_i = 0, the selector stays on ref_clk_i and on_pll_o stays 0.
- R5: If lock_i falls while the synthesized clock is active, core_clk_o returns to ref_clk_i and on_pll_o returns to 0.
- R6: Clearing sel_pll_i while the synthesized clock is active returns core_clk_o to ref_clk_i and on_pll_o to 0.
- R7: The two source gates are never open at once. No high or low phase of core_clk_o is shorter than the shorter half period of the two sources.
- R8: on_pll_o reads 1 once the synthesized gate has been open for a full cycle of that clock. It reads 0 once the pin-clock gate has been open for a full cycle of that clock.
- R9: A gate opens or closes only at the second falling edge of its own clock after its request changes (two-stage synchronizer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Input-pin clock, the default source |
| pll_clk_i | input | 1 | Synthesized clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| sel_pll_i | input | 1 | Request for the synthesized clock, from the control register |
| lock_i | input | 1 | Synthesizer lock indication |
| core_clk_o | output | 1 | Gated core clock |
| on_pll_o | output | 1 | 1 when the synthesized clock is the active source |

## Verification
A leg whose enable rose while the other was still open would show as a short phase on core_clk_o. This would appear at the first handover after the fault. The phase monitor catches it without waiting for a steady state. A stuck synchronizer or a wrong arbitration shows within about a dozen reference cycles: core_clk_o stays with the wrong source, or sits flat low, when compared half-cycle by half-cycle against the expected source. A status register that ignores the gated edges shows as on_pll_o disagreeing with the source that core_clk_o is tracking.

// File: rtl/clk_src_switch_pkg.sv
// Shared constants and types for the two-source clock selector.
// Assumes exactly one fallback source at index SRC_REF.
package clk_src_switch_pkg;
    localparam int NUM_SRC = 2;
    localparam int SRC_REF = 0;
    localparam int SRC_PLL = 1;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/clk_src_sync.sv
// Falling-edge synchronizer chain of STAGES flops with a chosen reset value.
// Assumes rst_n is held for at least STAGES cycles of clk_i.
module clk_src_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the chain on falling edges.
    always_ff @(negedge clk_i) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clk_src_leg.sv
// One source leg: synchronizes its enable request into its own clock on
// falling edges and ANDs the clock with the resulting enable.
// Assumes the enable changes only while clk_i is low (guaranteed by negedge flops).
module clk_src_leg #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_EN      = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    output logic en_o,
    output logic gclk_o
);
    clk_src_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_EN)) i_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (req_i),
        .q_o   (en_o)
    );

    // Gate the source; en_o only moves while clk_i is low.
    assign gclk_o = clk_i & en_o;

    if (SYNC_STAGES == 2) begin : g_chk
        // R9
        en_rise_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
            $rose(en_o) |-> $past(req_i, 2));
        // R9
        en_fall_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
            $fell(en_o) |-> !$past(req_i, 2));
    end
endmodule

// File: rtl/clk_src_arb.sv
// Prioritizes source wishes and applies the break-before-make interlock.
// The synthesized source wins only when selected and locked; otherwise the
// reference source is wanted. A leg may request only while every other leg is off.
module clk_src_arb
    import clk_src_switch_pkg::*;
(
    input  logic     sel_pll_i,
    input  logic     lock_i,
    input  src_vec_t en_i,
    output src_vec_t req_o
);
    src_vec_t want;

    // Priority: locked synthesized clock first, reference as fallback.
    always_comb begin
        want          = '0;
        want[SRC_PLL] = sel_pll_i & lock_i;
        want[SRC_REF] = ~want[SRC_PLL];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
        src_vec_t others;
        // Collect the enables of every other leg.
        always_comb begin
            others    = en_i;
            others[i] = 1'b0;
        end
        assign req_o[i] = want[i] & ~(|others);
    end
endmodule

// File: rtl/clk_src_switch.sv
// Top: two gated source legs, arbiter, output OR and active-source status.
// Assumes both clocks run during reset and reset is long enough for both
// synchronizer chains to load their reset values.
module clk_src_switch
    import clk_src_switch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk_i,
    input  logic pll_clk_i,
    input  logic rst_n,
    input  logic sel_pll_i,
    input  logic lock_i,
    output logic core_clk_o,
    output logic on_pll_o
);
    src_vec_t src_clk, en, req, gclk;

    assign src_clk[SRC_REF] = ref_clk_i;
    assign src_clk[SRC_PLL] = pll_clk_i;

    clk_src_arb i_arb (
        .sel_pll_i (sel_pll_i),
        .lock_i    (lock_i),
        .en_i      (en),
        .req_o     (req)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
        clk_src_leg #(
            .SYNC_STAGES (SYNC_STAGES),
            .RST_EN      ((i == SRC_REF) ? 1'b1 : 1'b0)
        ) i_leg (
            .clk_i  (src_clk[i]),
            .rst_n  (rst_n),
            .req_i  (req[i]),
            .en_o   (en[i]),
            .gclk_o (gclk[i])
        );
    end

    // Output: pin clock straight through in reset, else OR of gated legs.
    assign core_clk_o = rst_n ? (|gclk) : ref_clk_i;

    // Status follows the enable of whichever leg is producing edges.
    always_ff @(posedge core_clk_o) begin
        if (!rst_n) on_pll_o <= 1'b0;
        else        on_pll_o <= en[SRC_PLL];
    end

    // R7
    gates_excl_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        $onehot0(en));
    // R8
    pll_status_chk: assert property (@(posedge pll_clk_i) disable iff (!rst_n)
        ($past(en[SRC_PLL]) && en[SRC_PLL]) |-> on_pll_o);
    // R8
    ref_status_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        ($past(en[SRC_REF]) && en[SRC_REF]) |-> !on_pll_o);
endmodule

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;
    localparam real CLK_PERIOD = 10.0;
    localparam real PLL_PERIOD = 7.0;
    localparam real MIN_PHASE  = 3.4;

    logic ref_clk = 0, pll_clk = 0, rst_n = 0, sel = 0, lock = 0;
    logic core_clk, on_pll;
    int checks = 0, errors = 0, glitches = 0;
    bit done = 0;
    realtime last_edge = 0;

    clk_src_switch i_clk_src_switch (
        .ref_clk_i (ref_clk), .pll_clk_i (pll_clk), .rst_n (rst_n),
        .sel_pll_i (sel), .lock_i (lock),
        .core_clk_o (core_clk), .on_pll_o (on_pll)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
    always #(PLL_PERIOD/2) pll_clk = ~pll_clk;

    // R7 phase monitor on every output transition
    always @(core_clk) begin
        if ($realtime > 1.0 && last_edge > 0 && ($realtime - last_edge) < MIN_PHASE)
            glitches++;
        last_edge = $realtime;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare core clock against a source for n cycles, away from edges.
    task automatic expect_src(input bit pll, input int n, input string tag);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if (pll) begin
                @(posedge pll_clk); #1; if (core_clk !== 1'b1) bad++;
                @(negedge pll_clk); #1; if (core_clk !== 1'b0) bad++;
            end else begin
                @(posedge ref_clk); #2; if (core_clk !== 1'b1) bad++;
                @(negedge ref_clk); #2; if (core_clk !== 1'b0) bad++;
            end
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic settle();
        repeat (12) @(posedge ref_clk);
    endtask

    task automatic t_reset();
        expect_src(0, 6, "R1 core follows ref in reset");
        #1; check(on_pll === 1'b0, "R1 status in reset", on_pll, 0);
        @(posedge ref_clk); #1 rst_n = 1;
    endtask

    task automatic t_idle();
        settle();
        expect_src(0, 8, "R2 ref after reset");
        check(on_pll === 1'b0, "R2 status ref", on_pll, 0);
    endtask

    task automatic t_no_lock();
        sel = 1; lock = 0;
        settle();
        expect_src(0, 8, "R4 unlocked stays ref");
        check(on_pll === 1'b0, "R4 status stays ref", on_pll, 0);
    endtask

    task automatic t_to_pll(input string tag);
        lock = 1; sel = 1;
        settle();
        expect_src(1, 10, tag);
        check(on_pll === 1'b1, "R3 status pll", on_pll, 1);
    endtask

    task automatic t_lock_loss();
        lock = 0;
        settle();
        expect_src(0, 8, "R5 lock loss back to ref");
        check(on_pll === 1'b0, "R5 status ref", on_pll, 0);
    endtask

    task automatic t_deselect();
        sel = 0;
        settle();
        expect_src(0, 8, "R6 deselect back to ref");
        check(on_pll === 1'b0, "R6 status ref", on_pll, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            check(glitches == 0, "R7 no short phase on core clock", glitches, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_idle();
        t_no_lock();
        t_to_pll("R3 switch to pll");
        t_lock_loss();
        t_to_pll("R3 R8 second switch to pll");
        t_deselect();
        for (int r = 0; r < 3; r++) begin
            t_to_pll("R3 R9 repeated switch to pll");
            t_deselect();
        end
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule